// File: doc/BRIEF.md
# Address-Range Breakpoint Unit with Occurrence and Trace Counters

This block watches a stream of memory accesses and requests entry into debug mode when an access lands inside a programmed address window. The window is bounded by a low and a high limit, and both limits are inclusive. An access counts only if three things agree with the programmed configuration: its direction (read or write), the bus it came from (core or DMA), and the data space it targets (X or Y). An access that carries a conditional-jump target counts only when its taken flag is set.

An occurrence counter delays the break. Software preloads the counter with N-1. Each qualifying in-window access while the counter is non-zero decrements it by one. The access that arrives while the counter is already zero raises the break instead, so the break lands on the Nth hit. After firing, the unit stays quiet until the counter is reloaded or cleared, or the configuration is rewritten.

A separate trace-step counter counts completed instructions and requests debug entry when it steps down to zero. Both event sources have a sticky status bit that a status read clears.

Top module: `brk_range_unit`

## Requirements
- R1: An access is in the window when `lim_lo <= acc_addr <= lim_hi` (unsigned). Both bounds are inclusive, and an address equal to either limit is a hit.
- R2: `cfg_en` selects the access directions that can hit: 00 none, 01 writes only (`acc_is_write`=1), 10 reads only, 11 both.
- R3: `cfg_src` selects the monitored bus. Bit 1 must equal `acc_is_dma` and bit 0 must equal `acc_is_y`: 00 X core, 01 Y core, 10 X DMA, 11 Y DMA.
- R4: A qualifying in-window access decrements a non-zero `brk_count` by one. A qualifying access that arrives with `brk_count` zero leaves it at zero and fires the break, so a preload of N-1 fires on the Nth hit.
- R5: `brk_req` is a one-cycle pulse. It appears two clock edges after the access is presented. After a firing, further hits neither fire nor change the counter until `cnt_load`, `cnt_clear` or `cfg_wr` rearms the unit.
- R6: An access flagged `acc_is_jump` counts only when `acc_taken` is 1.
- R7: `brk_sticky` sets when the break fires and clears on `stat_rd`. A firing in the same cycle as `stat_rd` wins.
- R8: Synchronous reset clears `cfg_en`, `cfg_src`, both counters, both requests and both sticky bits.
- R9: When `trc_en` is 1, each `instr_done` without `instr_killed` decrements a non-zero `trc_count`. The step that reaches zero gives a one-cycle `trc_req` on the next edge and sets `trc_sticky`, which `stat_rd` clears. A count of zero neither steps nor requests.
- R10: `dbg_enter` clears `trc_count`, and `trc_load` takes priority over it.
- R11: `cnt_load` loads `brk_count` from `cnt_load_val`. `cnt_clear` zeroes it. A load takes priority over a clear, and either takes priority over a hit in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_valid | input | 1 | An access is present this cycle |
| acc_addr | input | AW | Access address |
| acc_is_write | input | 1 | 1 = write, 0 = read |
| acc_is_dma | input | 1 | 1 = DMA slot, 0 = core slot |
| acc_is_y | input | 1 | 1 = Y space, 0 = X space |
| acc_is_jump | input | 1 | Address is a conditional-jump target |
| acc_taken | input | 1 | The conditional jump is taken |
| lim_lo | input | AW | Inclusive low limit |
| lim_hi | input | AW | Inclusive high limit |
| cfg_wr | input | 1 | Write `cfg_en`/`cfg_src` and rearm |
| cfg_en | input | 2 | Direction enable field |
| cfg_src | input | 2 | Bus/space select field |
| cnt_load | input | 1 | Load occurrence counter |
| cnt_clear | input | 1 | Zero occurrence counter |
| cnt_load_val | input | CW | Occurrence preload (N-1) |
| stat_rd | input | 1 | Status read; clears sticky bits |
| trc_en | input | 1 | Trace mode enable |
| instr_done | input | 1 | An instruction completed |
| instr_killed | input | 1 | The completed instruction was killed |
| trc_load | input | 1 | Load trace counter |
| trc_load_val | input | CW | Trace preload |
| dbg_enter | input | 1 | Debug mode entered; clears trace counter |
| brk_req | output | 1 | Breakpoint debug-entry pulse |
| brk_sticky | output | 1 | Breakpoint occurred |
| brk_count | output | CW | Occurrence counter value |
| trc_req | output | 1 | Trace debug-entry pulse |
| trc_sticky | output | 1 | Trace occurrence |
| trc_count | output | CW | Trace counter value |

## Verification
The assertions check several rules on every cycle:
- a disabled direction field or an untaken jump never reaches the capture stage;
- a non-zero occurrence count steps down by exactly one per counted hit, and a load lands exactly;
- a break pulse without a rearm is never followed by another, and the sticky bit is always set alongside it;
- the trace count holds when nothing steps it and reads zero after debug entry.

Only the bench scenarios can show the rest:
- the inclusive window edges, swept over every address;
- the full direction and source decoding tables;
- that the Nth hit, and no earlier one, fires;
- status-read priority;
- that reset clears the configuration in mid-operation.

// File: rtl/brk_pkg.sv
package brk_pkg;
  typedef enum logic [1:0] {
    EN_OFF = 2'b00,
    EN_WR  = 2'b01,
    EN_RD  = 2'b10,
    EN_RW  = 2'b11
  } brk_en_e;

  // bit 1 of the select field picks the DMA slot, bit 0 picks Y space
  function automatic logic src_match(logic [1:0] sel, logic is_dma, logic is_y);
    return (sel[1] == is_dma) && (sel[0] == is_y);
  endfunction

  function automatic logic dir_match(brk_en_e en, logic is_wr);
    return is_wr ? en[0] : en[1];
  endfunction
endpackage

// File: rtl/brk_addr_latch.sv
module brk_addr_latch
  import brk_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          acc_valid,
  input  logic [AW-1:0] acc_addr,
  input  logic          acc_is_write,
  input  logic          acc_is_dma,
  input  logic          acc_is_y,
  input  logic          acc_is_jump,
  input  logic          acc_taken,
  input  brk_en_e       en,
  input  logic [1:0]    src,
  output logic          cap_valid,
  output logic [AW-1:0] cap_addr
);
  logic slot_ok, qualify;

  assign slot_ok = src_match(src, acc_is_dma, acc_is_y);
  assign qualify = acc_valid && slot_ok && dir_match(en, acc_is_write)
                   && (!acc_is_jump || acc_taken);

  always_ff @(posedge clk) begin
    if (rst) begin
      cap_valid <= 1'b0;
      cap_addr  <= '0;
    end else begin
      cap_valid <= qualify;
      if (slot_ok) cap_addr <= acc_addr;
    end
  end

  assert_off_no_capture_R2: assert property (@(posedge clk) disable iff (rst)
    (en == EN_OFF) |=> !cap_valid);
  assert_untaken_jump_R6: assert property (@(posedge clk) disable iff (rst)
    (acc_valid && acc_is_jump && !acc_taken) |=> !cap_valid);
endmodule

// File: rtl/brk_window_cmp.sv
module brk_window_cmp #(
  parameter int AW = 32
) (
  input  logic [AW-1:0] addr,
  input  logic [AW-1:0] lo,
  input  logic [AW-1:0] hi,
  output logic          in_win
);
  logic above_lo, below_hi;

  assign above_lo = (addr >= lo);
  assign below_hi = (addr <= hi);
  assign in_win   = above_lo && below_hi;
endmodule

// File: rtl/brk_occ_counter.sv
module brk_occ_counter #(
  parameter int CW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          hit,
  input  logic          rearm,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  input  logic          clear,
  input  logic          stat_rd,
  output logic [CW-1:0] count,
  output logic          brk_req,
  output logic          sticky
);
  localparam logic [CW-1:0] ONE = {{(CW-1){1'b0}}, 1'b1};

  logic armed, counted, fire;

  assign counted = !load && !clear && hit && armed;
  assign fire    = counted && (count == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      count   <= '0;
      armed   <= 1'b1;
      brk_req <= 1'b0;
      sticky  <= 1'b0;
    end else begin
      brk_req <= fire;
      if (load) begin
        count <= load_val;
        armed <= 1'b1;
      end else if (clear) begin
        count <= '0;
        armed <= 1'b1;
      end else if (fire) begin
        armed <= 1'b0;
      end else if (counted) begin
        count <= count - ONE;
      end
      if (rearm && !fire) armed <= 1'b1;
      if (fire) sticky <= 1'b1;
      else if (stat_rd) sticky <= 1'b0;
    end
  end

  assert_single_pulse_R5: assert property (@(posedge clk) disable iff (rst)
    (brk_req && !load && !clear && !rearm) |=> !brk_req);
  assert_step_down_R4: assert property (@(posedge clk) disable iff (rst)
    (hit && armed && !load && !clear && count != '0) |=> (count == $past(count) - ONE));
  assert_sticky_with_req_R7: assert property (@(posedge clk) disable iff (rst)
    brk_req |-> sticky);
  assert_load_lands_R11: assert property (@(posedge clk) disable iff (rst)
    load |=> (count == $past(load_val)));
endmodule

// File: rtl/brk_trace_counter.sv
module brk_trace_counter #(
  parameter int CW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          trc_en,
  input  logic          instr_done,
  input  logic          instr_killed,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  input  logic          dbg_enter,
  input  logic          stat_rd,
  output logic [CW-1:0] count,
  output logic          trc_req,
  output logic          sticky
);
  localparam logic [CW-1:0] ONE = {{(CW-1){1'b0}}, 1'b1};

  logic step, reach_zero;

  assign step       = !load && !dbg_enter && trc_en && instr_done && !instr_killed
                      && (count != '0);
  assign reach_zero = step && (count == ONE);

  always_ff @(posedge clk) begin
    if (rst) begin
      count   <= '0;
      trc_req <= 1'b0;
      sticky  <= 1'b0;
    end else begin
      trc_req <= reach_zero;
      if (load) count <= load_val;
      else if (dbg_enter) count <= '0;
      else if (step) count <= count - ONE;
      if (reach_zero) sticky <= 1'b1;
      else if (stat_rd) sticky <= 1'b0;
    end
  end

  assert_hold_when_idle_R9: assert property (@(posedge clk) disable iff (rst)
    (!load && !dbg_enter && !(trc_en && instr_done && !instr_killed)) |=> $stable(count));
  assert_req_at_zero_R9: assert property (@(posedge clk) disable iff (rst)
    trc_req |-> (count == '0) && sticky);
  assert_entry_clears_R10: assert property (@(posedge clk) disable iff (rst)
    (dbg_enter && !load) |=> (count == '0));
endmodule

// File: rtl/brk_range_unit.sv
module brk_range_unit
  import brk_pkg::*;
#(
  parameter int AW = 32,
  parameter int CW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          acc_valid,
  input  logic [AW-1:0] acc_addr,
  input  logic          acc_is_write,
  input  logic          acc_is_dma,
  input  logic          acc_is_y,
  input  logic          acc_is_jump,
  input  logic          acc_taken,
  input  logic [AW-1:0] lim_lo,
  input  logic [AW-1:0] lim_hi,
  input  logic          cfg_wr,
  input  logic [1:0]    cfg_en,
  input  logic [1:0]    cfg_src,
  input  logic          cnt_load,
  input  logic          cnt_clear,
  input  logic [CW-1:0] cnt_load_val,
  input  logic          stat_rd,
  input  logic          trc_en,
  input  logic          instr_done,
  input  logic          instr_killed,
  input  logic          trc_load,
  input  logic [CW-1:0] trc_load_val,
  input  logic          dbg_enter,
  output logic          brk_req,
  output logic          brk_sticky,
  output logic [CW-1:0] brk_count,
  output logic          trc_req,
  output logic          trc_sticky,
  output logic [CW-1:0] trc_count
);
  brk_en_e       en_q;
  logic [1:0]    src_q;
  logic          cap_valid, in_win;
  logic [AW-1:0] cap_addr;

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q  <= EN_OFF;
      src_q <= 2'b00;
    end else if (cfg_wr) begin
      en_q  <= brk_en_e'(cfg_en);
      src_q <= cfg_src;
    end
  end

  brk_addr_latch #(.AW(AW)) u_latch (
    .clk(clk), .rst(rst), .acc_valid(acc_valid), .acc_addr(acc_addr),
    .acc_is_write(acc_is_write), .acc_is_dma(acc_is_dma), .acc_is_y(acc_is_y),
    .acc_is_jump(acc_is_jump), .acc_taken(acc_taken), .en(en_q), .src(src_q),
    .cap_valid(cap_valid), .cap_addr(cap_addr)
  );

  brk_window_cmp #(.AW(AW)) u_cmp (
    .addr(cap_addr), .lo(lim_lo), .hi(lim_hi), .in_win(in_win)
  );

  brk_occ_counter #(.CW(CW)) u_occ (
    .clk(clk), .rst(rst), .hit(cap_valid && in_win), .rearm(cfg_wr),
    .load(cnt_load), .load_val(cnt_load_val), .clear(cnt_clear), .stat_rd(stat_rd),
    .count(brk_count), .brk_req(brk_req), .sticky(brk_sticky)
  );

  brk_trace_counter #(.CW(CW)) u_trc (
    .clk(clk), .rst(rst), .trc_en(trc_en), .instr_done(instr_done),
    .instr_killed(instr_killed), .load(trc_load), .load_val(trc_load_val),
    .dbg_enter(dbg_enter), .stat_rd(stat_rd),
    .count(trc_count), .trc_req(trc_req), .sticky(trc_sticky)
  );

  assert_reset_clears_R8: assert property (@(posedge clk)
    rst |=> (en_q == EN_OFF) && (src_q == 2'b00) && !brk_req && !trc_req);
endmodule

// File: tb/tb_brk_range_unit.sv
module tb_brk_range_unit;
  localparam int AW = 8;
  localparam int CW = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic acc_valid = 0, acc_is_write = 0, acc_is_dma = 0, acc_is_y = 0;
  logic acc_is_jump = 0, acc_taken = 0;
  logic [AW-1:0] acc_addr = '0, lim_lo = '0, lim_hi = '0;
  logic cfg_wr = 0;
  logic [1:0] cfg_en = 0, cfg_src = 0;
  logic cnt_load = 0, cnt_clear = 0, stat_rd = 0;
  logic [CW-1:0] cnt_load_val = '0, trc_load_val = '0;
  logic trc_en = 0, instr_done = 0, instr_killed = 0, trc_load = 0, dbg_enter = 0;
  logic brk_req, brk_sticky, trc_req, trc_sticky;
  logic [CW-1:0] brk_count, trc_count;

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  brk_range_unit #(.AW(AW), .CW(CW)) dut (
    .clk(clk), .rst(rst), .acc_valid(acc_valid), .acc_addr(acc_addr),
    .acc_is_write(acc_is_write), .acc_is_dma(acc_is_dma), .acc_is_y(acc_is_y),
    .acc_is_jump(acc_is_jump), .acc_taken(acc_taken), .lim_lo(lim_lo), .lim_hi(lim_hi),
    .cfg_wr(cfg_wr), .cfg_en(cfg_en), .cfg_src(cfg_src), .cnt_load(cnt_load),
    .cnt_clear(cnt_clear), .cnt_load_val(cnt_load_val), .stat_rd(stat_rd),
    .trc_en(trc_en), .instr_done(instr_done), .instr_killed(instr_killed),
    .trc_load(trc_load), .trc_load_val(trc_load_val), .dbg_enter(dbg_enter),
    .brk_req(brk_req), .brk_sticky(brk_sticky), .brk_count(brk_count),
    .trc_req(trc_req), .trc_sticky(trc_sticky), .trc_count(trc_count)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic set_cfg(input logic [1:0] en, input logic [1:0] src);
    @(negedge clk); cfg_en = en; cfg_src = src; cfg_wr = 1;
    @(negedge clk); cfg_wr = 0;
  endtask

  task automatic load_cnt(input logic [CW-1:0] v);
    @(negedge clk); cnt_load = 1; cnt_load_val = v;
    @(negedge clk); cnt_load = 0;
  endtask

  // presents one access, returns brk_req two edges later
  task automatic access(input logic [AW-1:0] a, input logic wr, input logic dma,
                        input logic y, input logic jmp, input logic tk, output logic got);
    @(negedge clk);
    acc_valid = 1; acc_addr = a; acc_is_write = wr; acc_is_dma = dma;
    acc_is_y = y; acc_is_jump = jmp; acc_taken = tk;
    @(negedge clk); acc_valid = 0; acc_is_jump = 0;
    @(negedge clk); got = brk_req;
  endtask

  task automatic trc_step(input logic killed);
    @(negedge clk); instr_done = 1; instr_killed = killed;
    @(negedge clk); instr_done = 0; instr_killed = 0;
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    logic got;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R8: reset state
    chk("R8 brk_req reset", brk_req, 0);
    chk("R8 brk_sticky reset", brk_sticky, 0);
    chk("R8 brk_count reset", brk_count, 0);
    chk("R8 trc_count reset", trc_count, 0);
    chk("R8 trc_sticky reset", trc_sticky, 0);

    // R1: exhaustive sweep for three windows
    set_cfg(2'b11, 2'b00);
    for (int w = 0; w < 3; w++) begin
      lim_lo = (w == 0) ? 8'h40 : (w == 1) ? 8'h55 : 8'h00;
      lim_hi = (w == 0) ? 8'h9F : (w == 1) ? 8'h55 : 8'hFF;
      for (int a = 0; a < 256; a++) begin
        load_cnt(0);
        access(a[7:0], a[0], 0, 0, 0, 0, got);
        chk($sformatf("R1 window w%0d addr %0h", w, a), got,
            (a >= lim_lo && a <= lim_hi) ? 1 : 0);
      end
    end
    lim_lo = 8'h20; lim_hi = 8'h30;

    // R2: direction decoding
    for (int e = 0; e < 4; e++) begin
      set_cfg(e[1:0], 2'b00);
      for (int wr = 0; wr < 2; wr++) begin
        load_cnt(0);
        access(8'h25, wr[0], 0, 0, 0, 0, got);
        chk($sformatf("R2 en=%0d wr=%0d", e, wr), got, wr ? e[0] : e[1]);
      end
    end

    // R3: source decoding
    for (int s = 0; s < 4; s++) begin
      set_cfg(2'b11, s[1:0]);
      for (int b = 0; b < 4; b++) begin
        load_cnt(0);
        access(8'h28, 1, b[1], b[0], 0, 0, got);
        chk($sformatf("R3 sel=%0d dma=%0d y=%0d", s, b[1], b[0]), got, (s == b) ? 1 : 0);
      end
    end

    // R6: conditional jump targets
    set_cfg(2'b11, 2'b00);
    load_cnt(0);
    access(8'h22, 0, 0, 0, 1, 0, got); chk("R6 untaken jump", got, 0);
    chk("R6 untaken count", brk_count, 0);
    access(8'h22, 0, 0, 0, 1, 1, got); chk("R6 taken jump", got, 1);

    // R4: Nth hit fires
    for (int n = 1; n <= 5; n++) begin
      load_cnt(n[7:0] - 8'd1);
      for (int k = 1; k <= n; k++) begin
        access(8'h2A, 0, 0, 0, 0, 0, got);
        chk($sformatf("R4 n=%0d hit %0d fire", n, k), got, (k == n) ? 1 : 0);
        chk($sformatf("R4 n=%0d hit %0d count", n, k), brk_count, (k < n) ? n - 1 - k : 0);
      end
    end

    // R5: pulse width, disarm, rearm by cfg write
    load_cnt(0);
    access(8'h20, 0, 0, 0, 0, 0, got); chk("R5 fires", got, 1);
    @(negedge clk); chk("R5 one cycle", brk_req, 0);
    access(8'h20, 0, 0, 0, 0, 0, got); chk("R5 disarmed", got, 0);
    chk("R5 disarmed count", brk_count, 0);
    set_cfg(2'b11, 2'b00);
    access(8'h30, 0, 0, 0, 0, 0, got); chk("R5 rearm by cfg", got, 1);

    // R11: clear and load priority
    load_cnt(5);
    @(negedge clk); cnt_clear = 1;
    @(negedge clk); cnt_clear = 0;
    chk("R11 clear zeroes", brk_count, 0);
    @(negedge clk); cnt_clear = 1; cnt_load = 1; cnt_load_val = 8'd9;
    @(negedge clk); cnt_clear = 0; cnt_load = 0;
    chk("R11 load over clear", brk_count, 9);
    @(negedge clk); cnt_clear = 1;
    @(negedge clk); cnt_clear = 0;
    access(8'h24, 0, 0, 0, 0, 0, got); chk("R11 fires after clear", got, 1);

    // R7: sticky set and clear, fire wins
    chk("R7 sticky set", brk_sticky, 1);
    @(negedge clk); stat_rd = 1;
    @(negedge clk); stat_rd = 0;
    chk("R7 sticky cleared", brk_sticky, 0);
    load_cnt(0);
    @(negedge clk); acc_valid = 1; acc_addr = 8'h26; acc_is_dma = 0; acc_is_y = 0;
    @(negedge clk); acc_valid = 0; stat_rd = 1;
    @(negedge clk); stat_rd = 0;
    chk("R7 fire beats read req", brk_req, 1);
    chk("R7 fire beats read sticky", brk_sticky, 1);
    @(negedge clk); stat_rd = 1;
    @(negedge clk); stat_rd = 0;

    // R9: trace stepping
    @(negedge clk); trc_load = 1; trc_load_val = 8'd3;
    @(negedge clk); trc_load = 0;
    trc_step(0); chk("R9 no step when disabled", trc_count, 3);
    trc_en = 1;
    trc_step(1); chk("R9 killed ignored", trc_count, 3);
    for (int i = 2; i >= 0; i--) begin
      trc_step(0);
      chk($sformatf("R9 count %0d", i), trc_count, i);
      chk($sformatf("R9 req at %0d", i), trc_req, (i == 0) ? 1 : 0);
    end
    @(negedge clk); chk("R9 req one cycle", trc_req, 0);
    chk("R9 trc sticky", trc_sticky, 1);
    trc_step(0); chk("R9 zero holds", trc_count, 0);
    chk("R9 zero no req", trc_req, 0);
    @(negedge clk); stat_rd = 1;
    @(negedge clk); stat_rd = 0;
    chk("R9 trc sticky cleared", trc_sticky, 0);

    // R10: debug entry clears, load wins
    @(negedge clk); trc_load = 1; trc_load_val = 8'd7;
    @(negedge clk); trc_load = 0; dbg_enter = 1;
    @(negedge clk); dbg_enter = 0;
    chk("R10 entry clears", trc_count, 0);
    @(negedge clk); trc_load = 1; trc_load_val = 8'd4; dbg_enter = 1;
    @(negedge clk); trc_load = 0; dbg_enter = 0;
    chk("R10 load over entry", trc_count, 4);

    // R8: reset mid-operation
    load_cnt(7);
    @(negedge clk); rst = 1;
    @(negedge clk); rst = 0;
    chk("R8 count cleared", brk_count, 0);
    chk("R8 trc cleared", trc_count, 0);
    access(8'h25, 1, 0, 0, 0, 0, got); chk("R8 cfg cleared no fire", got, 0);

    finished = 1;
    summary();
    $finish;
  end
endmodule